// File: doc/BRIEF.md
# Link-Level ACK/NAK Retry Engine

This block provides the reliability layer of a serial link. On the sending side it gives every outgoing packet a 12-bit sequence number and keeps a copy in a replay store. Each copy stays there until the far end acknowledges it. Acknowledgments are cumulative. A negative acknowledgment, or a timer that runs out with packets still unacknowledged, makes the block resend every outstanding packet. It resends them oldest first, one per cycle (go-back-N).

On the receiving side it compares each arriving packet's sequence number with the one it expects, and it also checks the packet's CRC-good flag. It passes good in-order packets upward and answers with ACK or NAK control packets. It drops duplicates and packets that arrive out of order. After several replays in a row with no forward progress, the block asks for link retraining.

The upper layer offers packets through a valid/ready pair. Sent and resent packets go out on a valid-only stream, which the physical side always accepts. Received packets arrive with their sequence number and CRC flag. Control packets flow in both directions on separate ports.

Top module: `link_retry_engine`

## Requirements
- R1: After reset the first new packet is sent with sequence number 0. Each later new packet carries the previous number plus one, modulo 4096, so 4095 is followed by 0.
- R2: After reset `up_ready` is high and no output is valid. A packet accepted at a clock edge (`up_valid` and `up_ready` both high) appears on `tx_valid`/`tx_seq`/`tx_data` in the cycle that follows that edge.
- R3: `up_ready` is low while REPLAY_DEPTH (32 by default) packets are unacknowledged. An ACK (`ctl_in_nak` = 0) naming sequence number s frees every outstanding packet up to and including s. An ACK naming a number that is not outstanding frees nothing.
- R4: A NAK (`ctl_in_nak` = 1) naming s first frees packets up to s, as an ACK would. The block then resends every remaining unacknowledged packet with its original number and data, oldest first, one per cycle. The first resent packet appears two cycles after the NAK edge. `up_ready` stays low until the last one is sent.
- R5: If packets stay unacknowledged for REPLAY_TIMEOUT cycles without an ACK that frees any of them, all of them are resent. The timer restarts when the last packet of a replay has been sent, so the gap between successive resends of a lone packet is REPLAY_TIMEOUT+1 cycles.
- R6: A received packet with `rx_crc_ok` = 1 and the expected sequence number is delivered on `dlv_valid`/`dlv_data` in the next cycle. It is also acknowledged with an ACK carrying its own number. The expected number is 0 after reset and then advances by one, modulo 4096.
- R7: A received packet with `rx_crc_ok` = 0, or with a sequence number 1 to 2047 ahead of the expected one, is dropped. It is answered with a NAK carrying the expected number minus one. Only one NAK is sent until the next good in-order packet arrives.
- R8: A good packet whose number lies 1 to 2048 behind the expected one is a duplicate. It is dropped and answered with an ACK carrying the expected number minus one.
- R9: `retrain_req` pulses for one cycle when the REPLAYS_BEFORE_RETRAIN-th (4th by default) replay starts with no freeing ACK since the first of them. That replay still runs, and the count starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upper layer offers a packet |
| up_data | input | DATA_W | Offered packet payload |
| up_ready | output | 1 | Block can accept a new packet |
| tx_valid | output | 1 | Packet on the outgoing stream |
| tx_seq | output | 12 | Sequence number of outgoing packet |
| tx_data | output | DATA_W | Outgoing packet payload |
| rx_valid | input | 1 | Received packet present |
| rx_seq | input | 12 | Received packet sequence number |
| rx_data | input | DATA_W | Received packet payload |
| rx_crc_ok | input | 1 | Received packet passed its integrity check |
| dlv_valid | output | 1 | Accepted packet delivered upward |
| dlv_data | output | DATA_W | Delivered packet payload |
| ctl_out_valid | output | 1 | Outgoing ACK/NAK control packet |
| ctl_out_nak | output | 1 | 1 = NAK, 0 = ACK |
| ctl_out_seq | output | 12 | Sequence number named by the control packet |
| ctl_in_valid | input | 1 | Incoming ACK/NAK control packet |
| ctl_in_nak | input | 1 | 1 = NAK, 0 = ACK |
| ctl_in_seq | input | 12 | Sequence number named by the incoming control packet |
| retrain_req | output | 1 | One-cycle request to retrain the link |

## Verification
The assertions rely on a few things about the inputs. Incoming control packets must name a sequence number that has been sent or was the last one acknowledged. Received sequence numbers must stay within half the number space of the expected one. The replay depth must be a power of two, no larger than 2048.

The stimulus respects all of this. ACK and NAK numbers come from the bench's own record of what it has sent. Random duplicates lag the expected number by at most four, and out-of-order packets run at most five ahead. The timer test waits with exactly one packet outstanding.

// File: rtl/retry_pkg.sv
package retry_pkg;
    localparam int SEQ_W = 12;
    localparam int HALF_SPACE = 1 << (SEQ_W - 1);
    typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/retry_store.sv
module retry_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_addr] <= wr_data;
    end

    assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/retry_tx.sv
module retry_tx
    import retry_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 32,
    parameter int TIMEOUT    = 256,
    parameter int MAX_REPLAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              tx_valid,
    output seq_t              tx_seq,
    output logic [DATA_W-1:0] tx_data,
    input  logic              ack_valid,
    input  logic              ack_nak,
    input  seq_t              ack_seq,
    output logic              retrain
);
    localparam int AW = $clog2(DEPTH);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam int CW = $clog2(MAX_REPLAY + 1);

    typedef struct packed {
        seq_t              next_seq;
        seq_t              acked;
        logic              replaying;
        seq_t              rep_seq;
        logic [TW-1:0]     timer;
        logic [CW-1:0]     rep_cnt;
        logic              retrain;
        logic              tx_valid;
        logic              tx_rep;
        seq_t              tx_seq;
        logic [DATA_W-1:0] tx_data;
    } tx_state_t;

    tx_state_t s_q, s_d;
    seq_t pending, ack_off, last_seq, pend_new;
    logic ack_hit, accept, start, wr_en;
    logic [DATA_W-1:0] rd_data;

    retry_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (s_q.next_seq[AW-1:0]),
        .wr_data (up_data),
        .rd_addr (s_q.rep_seq[AW-1:0]),
        .rd_data (rd_data)
    );

    assign pending  = s_q.next_seq - s_q.acked - 1'b1;
    assign ack_off  = ack_seq - s_q.acked;
    assign last_seq = s_q.next_seq - 1'b1;
    assign ack_hit  = ack_valid && (ack_off != '0) && (ack_off <= pending);
    assign up_ready = !s_q.replaying && (pending < SEQ_W'(DEPTH));
    assign accept   = up_valid && up_ready;

    always_comb begin
        s_d          = s_q;
        s_d.tx_valid = 1'b0;
        s_d.tx_rep   = 1'b0;
        s_d.retrain  = 1'b0;
        wr_en        = 1'b0;
        start        = 1'b0;
        if (ack_hit) begin
            s_d.acked   = ack_seq;
            s_d.rep_cnt = '0;
        end
        if (s_q.replaying) begin
            s_d.tx_valid = 1'b1;
            s_d.tx_rep   = 1'b1;
            s_d.tx_seq   = s_q.rep_seq;
            s_d.tx_data  = rd_data;
            s_d.rep_seq  = s_q.rep_seq + 1'b1;
            if (s_q.rep_seq == last_seq) begin
                s_d.replaying = 1'b0;
                s_d.timer     = '0;
            end
        end else begin
            if (accept) begin
                s_d.tx_valid = 1'b1;
                s_d.tx_seq   = s_q.next_seq;
                s_d.tx_data  = up_data;
                s_d.next_seq = s_q.next_seq + 1'b1;
                wr_en        = 1'b1;
            end
            if (ack_hit || pending == '0) begin
                s_d.timer = '0;
            end else if (s_q.timer == TW'(TIMEOUT - 1)) begin
                start = 1'b1;
            end else begin
                s_d.timer = s_q.timer + 1'b1;
            end
        end
        pend_new = s_d.next_seq - s_d.acked - 1'b1;
        if (ack_valid && ack_nak && pend_new != '0) start = 1'b1;
        if (start) begin
            s_d.replaying = 1'b1;
            s_d.rep_seq   = s_d.acked + 1'b1;
            s_d.timer     = '0;
            if (s_d.rep_cnt == CW'(MAX_REPLAY - 1)) begin
                s_d.rep_cnt = '0;
                s_d.retrain = 1'b1;
            end else begin
                s_d.rep_cnt = s_d.rep_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.acked <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid = s_q.tx_valid;
    assign tx_seq   = s_q.tx_seq;
    assign tx_data  = s_q.tx_data;
    assign retrain  = s_q.retrain;

    // R3: outstanding packets never exceed the store
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= SEQ_W'(DEPTH));
    // R4: resent packets leave in ascending order unless a NAK restarts them
    assert_replay_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tx_rep && $past(s_q.tx_rep) && !$past(ack_valid && ack_nak)
        |-> s_q.tx_seq == $past(s_q.tx_seq) + 1'b1);
    // R5: the timer starts from zero once a replay has finished
    assert_timer_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.replaying) |-> s_q.timer == '0);
    // R9: a retrain request comes with a replay in progress
    assert_retrain_with_replay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.retrain |-> s_q.replaying);
endmodule

// File: rtl/retry_rx.sv
module retry_rx
    import retry_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  seq_t              rx_seq,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_crc_ok,
    output logic              dlv_valid,
    output logic [DATA_W-1:0] dlv_data,
    output logic              ctl_valid,
    output logic              ctl_nak,
    output seq_t              ctl_seq
);
    typedef struct packed {
        seq_t              exp_seq;
        logic              nak_sent;
        logic              ctl_valid;
        logic              ctl_nak;
        seq_t              ctl_seq;
        logic              dlv_valid;
        logic [DATA_W-1:0] dlv_data;
    } rx_state_t;

    rx_state_t r_q, r_d;
    seq_t ahead, behind, last_good;

    assign ahead     = rx_seq - r_q.exp_seq;
    assign behind    = r_q.exp_seq - rx_seq;
    assign last_good = r_q.exp_seq - 1'b1;

    always_comb begin
        r_d           = r_q;
        r_d.ctl_valid = 1'b0;
        r_d.dlv_valid = 1'b0;
        if (rx_valid) begin
            if (rx_crc_ok && ahead == '0) begin
                r_d.dlv_valid = 1'b1;
                r_d.dlv_data  = rx_data;
                r_d.exp_seq   = r_q.exp_seq + 1'b1;
                r_d.nak_sent  = 1'b0;
                r_d.ctl_valid = 1'b1;
                r_d.ctl_nak   = 1'b0;
                r_d.ctl_seq   = rx_seq;
            end else if (rx_crc_ok && behind <= SEQ_W'(HALF_SPACE)) begin
                r_d.ctl_valid = 1'b1;
                r_d.ctl_nak   = 1'b0;
                r_d.ctl_seq   = last_good;
            end else if (!r_q.nak_sent) begin
                r_d.nak_sent  = 1'b1;
                r_d.ctl_valid = 1'b1;
                r_d.ctl_nak   = 1'b1;
                r_d.ctl_seq   = last_good;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dlv_valid = r_q.dlv_valid;
    assign dlv_data  = r_q.dlv_data;
    assign ctl_valid = r_q.ctl_valid;
    assign ctl_nak   = r_q.ctl_nak;
    assign ctl_seq   = r_q.ctl_seq;

    // R6: every delivery is acknowledged with the number just consumed
    assert_deliver_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dlv_valid |-> r_q.ctl_valid && !r_q.ctl_nak && r_q.ctl_seq == r_q.exp_seq - 1'b1);
    // R7: two NAKs never go out back to back
    assert_single_nak_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctl_valid && r_q.ctl_nak |=> !(r_q.ctl_valid && r_q.ctl_nak));
    // R7: after a NAK the NAK flag is held until good in-order data
    assert_nak_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctl_valid && r_q.ctl_nak |-> r_q.nak_sent);
endmodule

// File: rtl/link_retry_engine.sv
module link_retry_engine #(
    parameter int DATA_W                 = 32,
    parameter int REPLAY_DEPTH           = 32,
    parameter int REPLAY_TIMEOUT         = 256,
    parameter int REPLAYS_BEFORE_RETRAIN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          up_valid,
    input  logic [DATA_W-1:0]             up_data,
    output logic                          up_ready,
    output logic                          tx_valid,
    output logic [retry_pkg::SEQ_W-1:0]   tx_seq,
    output logic [DATA_W-1:0]             tx_data,
    input  logic                          rx_valid,
    input  logic [retry_pkg::SEQ_W-1:0]   rx_seq,
    input  logic [DATA_W-1:0]             rx_data,
    input  logic                          rx_crc_ok,
    output logic                          dlv_valid,
    output logic [DATA_W-1:0]             dlv_data,
    output logic                          ctl_out_valid,
    output logic                          ctl_out_nak,
    output logic [retry_pkg::SEQ_W-1:0]   ctl_out_seq,
    input  logic                          ctl_in_valid,
    input  logic                          ctl_in_nak,
    input  logic [retry_pkg::SEQ_W-1:0]   ctl_in_seq,
    output logic                          retrain_req
);
    retry_tx #(
        .DATA_W     (DATA_W),
        .DEPTH      (REPLAY_DEPTH),
        .TIMEOUT    (REPLAY_TIMEOUT),
        .MAX_REPLAY (REPLAYS_BEFORE_RETRAIN)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_valid  (up_valid),
        .up_data   (up_data),
        .up_ready  (up_ready),
        .tx_valid  (tx_valid),
        .tx_seq    (tx_seq),
        .tx_data   (tx_data),
        .ack_valid (ctl_in_valid),
        .ack_nak   (ctl_in_nak),
        .ack_seq   (ctl_in_seq),
        .retrain   (retrain_req)
    );

    retry_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_seq    (rx_seq),
        .rx_data   (rx_data),
        .rx_crc_ok (rx_crc_ok),
        .dlv_valid (dlv_valid),
        .dlv_data  (dlv_data),
        .ctl_valid (ctl_out_valid),
        .ctl_nak   (ctl_out_nak),
        .ctl_seq   (ctl_out_seq)
    );
endmodule

// File: tb/link_retry_engine_test.sv
module link_retry_engine_test;
    localparam int TMO = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0;
    logic [31:0] up_data = '0;
    logic        up_ready;
    logic        tx_valid;
    logic [11:0] tx_seq;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0;
    logic [11:0] rx_seq = '0;
    logic [31:0] rx_data = '0;
    logic        rx_crc_ok = 1'b0;
    logic        dlv_valid;
    logic [31:0] dlv_data;
    logic        ctl_out_valid;
    logic        ctl_out_nak;
    logic [11:0] ctl_out_seq;
    logic        ctl_in_valid = 1'b0;
    logic        ctl_in_nak = 1'b0;
    logic [11:0] ctl_in_seq = '0;
    logic        retrain_req;

    always #5 clk = ~clk;

    link_retry_engine #(.REPLAY_TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
        .up_ready(up_ready), .tx_valid(tx_valid), .tx_seq(tx_seq), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_seq(rx_seq), .rx_data(rx_data), .rx_crc_ok(rx_crc_ok),
        .dlv_valid(dlv_valid), .dlv_data(dlv_data), .ctl_out_valid(ctl_out_valid),
        .ctl_out_nak(ctl_out_nak), .ctl_out_seq(ctl_out_seq), .ctl_in_valid(ctl_in_valid),
        .ctl_in_nak(ctl_in_nak), .ctl_in_seq(ctl_in_seq), .retrain_req(retrain_req)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nseq   = 0;
    int ackm   = 4095;
    int rexp   = 0;
    bit rnak   = 1'b0;
    logic [31:0] tdata [4096];

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic send_ctl(input bit nak, input int seq);
        ctl_in_valid = 1'b1;
        ctl_in_nak   = nak;
        ctl_in_seq   = 12'(seq);
        tick();
        ctl_in_valid = 1'b0;
        ctl_in_nak   = 1'b0;
    endtask

    function automatic int wrap(input int v);
        return v & 4095;
    endfunction

    // Received-side model from R6, R7, R8
    task automatic rx_send(input int seq, input bit crc);
        bit ev = 1'b0, en = 1'b0, dv = 1'b0;
        int es = 0;
        int ahead = wrap(seq - rexp);
        int behind = wrap(rexp - seq);
        string tag = "R7";
        logic [31:0] d = $urandom;
        rx_valid  = 1'b1;
        rx_seq    = 12'(seq);
        rx_data   = d;
        rx_crc_ok = crc;
        if (crc && ahead == 0) begin
            tag = "R6"; dv = 1'b1; ev = 1'b1; es = seq;
            rexp = wrap(rexp + 1); rnak = 1'b0;
        end else if (crc && behind >= 1 && behind <= 2048) begin
            tag = "R8"; ev = 1'b1; es = wrap(rexp - 1);
        end else if (!rnak) begin
            ev = 1'b1; en = 1'b1; es = wrap(rexp - 1); rnak = 1'b1;
        end
        tick();
        rx_valid = 1'b0;
        chk(dlv_valid == dv && (!dv || dlv_data == d), tag, int'(dlv_valid), int'(dv));
        chk(ctl_out_valid == ev && (!ev || (ctl_out_nak == en && int'(ctl_out_seq) == es)),
            tag, ev ? int'(ctl_out_seq) : int'(ctl_out_valid), ev ? es : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        int seed;
        int filled;
        int t0;
        int nrep;
        int nret;
        int retcyc;
        int rt [8];
        seed = $urandom(32'h1f2e3d4c);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2: reset state
        chk(up_ready && !tx_valid && !ctl_out_valid && !dlv_valid && !retrain_req,
            "R2", int'(up_ready), 1);

        // R1, R2: first packets numbered from zero, one cycle latency
        for (int i = 0; i < 10; i++) begin
            up_valid = 1'b1;
            up_data  = $urandom;
            tdata[nseq] = up_data;
            tick();
            chk(tx_valid && int'(tx_seq) == nseq, "R1", int'(tx_seq), nseq);
            chk(tx_data == tdata[nseq], "R2", int'(tx_data), int'(tdata[nseq]));
            nseq = wrap(nseq + 1);
        end
        up_valid = 1'b0;
        send_ctl(1'b0, nseq - 1);
        ackm = nseq - 1;

        // R3: fill the store
        filled = 0;
        up_valid = 1'b1;
        while (up_ready && filled < 40) begin
            up_data = $urandom;
            tdata[nseq] = up_data;
            tick();
            nseq = wrap(nseq + 1);
            filled++;
        end
        up_valid = 1'b0;
        chk(filled == 32, "R3 full count", filled, 32);
        send_ctl(1'b0, ackm);
        chk(!up_ready, "R3 stale ack frees nothing", int'(up_ready), 0);
        send_ctl(1'b0, ackm + 5);
        ackm = ackm + 5;
        chk(up_ready, "R3 ack frees space", int'(up_ready), 1);
        filled = 0;
        up_valid = 1'b1;
        while (up_ready && filled < 40) begin
            up_data = $urandom;
            tdata[nseq] = up_data;
            tick();
            nseq = wrap(nseq + 1);
            filled++;
        end
        up_valid = 1'b0;
        chk(filled == 5, "R3 refill count", filled, 5);

        // R4: NAK replays the remainder in order
        send_ctl(1'b1, ackm + 6);
        ackm = ackm + 6;
        chk(!up_ready, "R4 blocked during replay", int'(up_ready), 0);
        for (int j = ackm + 1; j < nseq; j++) begin
            tick();
            chk(tx_valid && int'(tx_seq) == j && tx_data == tdata[j], "R4", int'(tx_seq), j);
        end
        chk(up_ready, "R4 unblocked after replay", int'(up_ready), 1);
        send_ctl(1'b0, nseq - 1);
        ackm = nseq - 1;

        // R5, R9: timer-driven replays of a lone packet
        up_valid = 1'b1;
        up_data  = $urandom;
        tdata[nseq] = up_data;
        tick();
        up_valid = 1'b0;
        t0 = cyc;
        nrep = 0;
        nret = 0;
        retcyc = -1;
        for (int k = 0; k < 600; k++) begin
            tick();
            if (tx_valid) begin
                if (nrep < 8) rt[nrep] = cyc;
                nrep++;
                chk(int'(tx_seq) == nseq && tx_data == tdata[nseq], "R5 resent packet",
                    int'(tx_seq), nseq);
            end
            if (retrain_req) begin
                nret++;
                retcyc = cyc;
            end
        end
        chk(nrep == 5, "R5 replay count", nrep, 5);
        chk(rt[0] - t0 == TMO + 1, "R5 first timeout", rt[0] - t0, TMO + 1);
        for (int i = 1; i < 5; i++)
            chk(rt[i] - rt[i-1] == TMO + 1, "R5 timer restart", rt[i] - rt[i-1], TMO + 1);
        chk(nret == 1, "R9 retrain pulses", nret, 1);
        chk(retcyc == rt[3] - 1, "R9 retrain timing", retcyc, rt[3] - 1);
        send_ctl(1'b0, nseq);
        nseq = wrap(nseq + 1);

        // R1: numbering wraps past 4095
        for (int i = 0; i < 4100; i++) begin
            up_valid     = 1'b1;
            up_data      = $urandom;
            ctl_in_valid = 1'b1;
            ctl_in_nak   = 1'b0;
            ctl_in_seq   = 12'(wrap(nseq - 1));
            tick();
            chk(tx_valid && int'(tx_seq) == nseq, "R1 wrap", int'(tx_seq), nseq);
            nseq = wrap(nseq + 1);
        end
        up_valid = 1'b0;
        ctl_in_valid = 1'b0;
        send_ctl(1'b0, wrap(nseq - 1));

        // R6, R7, R8: directed receive cases
        rx_send(0, 1'b1);
        rx_send(5, 1'b1);
        rx_send(1, 1'b0);
        rx_send(0, 1'b1);
        rx_send(1, 1'b1);
        rx_send(3, 1'b0);
        rx_send(2, 1'b1);

        // R6, R7, R8: random receive mix
        for (int i = 0; i < 400; i++) begin
            int kind = int'($urandom % 10);
            if (kind < 6)      rx_send(rexp, 1'b1);
            else if (kind == 6) rx_send(rexp, 1'b0);
            else if (kind < 9) rx_send(wrap(rexp - 1 - int'($urandom % 4)), 1'b1);
            else               rx_send(wrap(rexp + 1 + int'($urandom % 5)), 1'b1);
        end

        // R6: expected number wraps past 4095
        for (int i = 0; i < 4100; i++) rx_send(rexp, 1'b1);

        summary();
        $finish;
    end
endmodule